// File: doc/BRIEF.md
# Acknowledged Cross-Clock Word Mailbox

This block moves one data word at a time from a producer clock domain to a consumer clock domain without ever dropping a word. The producer offers a word with a valid strobe while `wr_ready_o` is high. The word is then held in a single register until the consumer has taken it. The consumer sees `rd_valid_o` with the word on `rd_data_o` and takes it with a one-cycle `rd_accept_i`. That accept travels back to the producer side and appears there as a one-cycle `wr_done_o` strobe. After that the mailbox can take the next word.

Either side can abandon the word in flight. `wr_clr_i` on the producer side and `rd_clr_i` on the consumer side both discard it. The consumer then stops showing it, and the producer gets `wr_ready_o` back without a `wr_done_o` strobe.

Every signal that crosses between the domains is a single bit: a toggle, or a level held through a handshake. Each one passes through a flop synchronizer of `SYNC_STAGES` stages. As a result the two clocks may be unrelated, or driven by the same clock net. Handing over one word costs several cycles of each clock.

Top module: `xdom_mailbox`

## Requirements
- R1: After reset, `wr_ready_o` is 1, `rd_valid_o` is 0 and `wr_done_o` is 0.
- R2: A write is taken at a write-clock edge where `wr_valid_i` and `wr_ready_o` are both high. With both clocks on one net, `rd_valid_o` is low after the first following edge and high after the second (`SYNC_STAGES` = 2). `rd_data_o` then equals the word written.
- R3: While `wr_ready_o` is low, `wr_valid_i` is ignored. The held word and `rd_data_o` stay unchanged, and no second word is delivered afterwards.
- R4: `rd_valid_o` stays high until the consumer accepts or a clear is seen. `rd_accept_i` while `rd_valid_o` is low has no effect, and a later write is delivered normally.
- R5: An accept makes `rd_valid_o` fall after that read edge. `wr_done_o` is then high for exactly one write cycle, after the second write edge that follows (same clock net). `wr_ready_o` goes high one cycle later.
- R6: A producer clear discards the pending word. `rd_valid_o` falls, `wr_ready_o` returns, `wr_done_o` does not pulse, and the discarded word never reappears.
- R7: A consumer clear while `rd_valid_o` is high makes `rd_valid_o` fall after that read edge. `wr_ready_o` returns and `wr_done_o` does not pulse.
- R8: A clear wins over a simultaneous action. `wr_clr_i` together with `wr_valid_i` starts no transfer. `rd_clr_i` together with `rd_accept_i` counts as a discard, so no `wr_done_o` is produced.
- R9: While `wr_ready_o` is low, `rd_data_o` is stable.
- R10: With two unrelated clocks, a sequence of words arrives complete and in order, with one `wr_done_o` per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Producer clock |
| rd_clk_i | input | 1 | Consumer clock (may be the same net as wr_clk_i) |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_valid_i | input | 1 | Producer offers a word |
| wr_data_i | input | DATA_W | Word offered |
| wr_clr_i | input | 1 | Producer-side discard request |
| wr_ready_o | output | 1 | Mailbox empty, write will be taken |
| wr_done_o | output | 1 | One-cycle strobe: consumer has taken the word |
| rd_valid_o | output | 1 | Word available to the consumer |
| rd_data_o | output | DATA_W | Held word |
| rd_accept_i | input | 1 | Consumer takes the word |
| rd_clr_i | input | 1 | Consumer-side discard request |

## Verification
With both clocks on one net, latency is exact. `rd_valid_o` rises two edges after the write edge and falls one edge after the accept. `wr_done_o` rises two edges after that, and `wr_ready_o` one edge later. The bench drives inputs on falling edges and samples on the falling edge after each counted rising edge, so each of these checks lands on its exact cycle. The clear handshakes and the unrelated-clock run have no fixed latency, so the bench waits for each result with a bounded loop. It then checks what must never appear in a window of many cycles: a `wr_done_o` strobe for a discarded word, or a reappearing `rd_valid_o`.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    WR_IDLE,
    WR_BUSY,
    WR_CLR_HOLD,
    WR_CLR_REL
  } wr_state_e;
endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xmb_wr_side.sv
module xmb_wr_side
  import xmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              clr_o,
  input  logic              take_s_i,
  input  logic              drop_s_i,
  input  logic              echo_s_i
);
  wr_state_e         state_q;
  logic              req_q, clr_q, take_q;
  logic [DATA_W-1:0] data_q;
  logic              closed;

  // handshake closed when taken/dropped parity matches request toggle
  assign closed = ((take_s_i ^ drop_s_i) == req_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      req_q   <= 1'b0;
      clr_q   <= 1'b0;
      data_q  <= '0;
      take_q  <= 1'b0;
    end else begin
      take_q <= take_s_i;
      unique case (state_q)
        WR_IDLE: begin
          if (clr_i) begin
            clr_q   <= 1'b1;
            state_q <= WR_CLR_HOLD;
          end else if (valid_i) begin
            data_q  <= data_i;
            req_q   <= ~req_q;
            state_q <= WR_BUSY;
          end
        end
        WR_BUSY: begin
          if (clr_i) begin
            clr_q   <= 1'b1;
            state_q <= WR_CLR_HOLD;
          end else if (closed) begin
            state_q <= WR_IDLE;
          end
        end
        WR_CLR_HOLD: begin
          if (closed && echo_s_i) begin
            clr_q   <= 1'b0;
            state_q <= WR_CLR_REL;
          end
        end
        WR_CLR_REL: begin
          if (!echo_s_i) state_q <= WR_IDLE;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == WR_IDLE);
  assign done_o  = take_s_i ^ take_q;
  assign req_o   = req_q;
  assign data_o  = data_q;
  assign clr_o   = clr_q;
endmodule

// File: rtl/xmb_rd_side.sv
module xmb_rd_side (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic clr_s_i,
  input  logic accept_i,
  input  logic clr_i,
  output logic valid_o,
  output logic take_o,
  output logic drop_o,
  output logic echo_o
);
  logic seen_q, take_q, drop_q, echo_q;
  logic pending;

  assign pending = (req_s_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      take_q <= 1'b0;
      drop_q <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      echo_q <= clr_s_i;
      // discard beats accept
      if (pending && (clr_i || clr_s_i)) begin
        seen_q <= req_s_i;
        drop_q <= ~drop_q;
      end else if (pending && accept_i) begin
        seen_q <= req_s_i;
        take_q <= ~take_q;
      end
    end
  end

  assign valid_o = pending && !clr_s_i;
  assign take_o  = take_q;
  assign drop_o  = drop_q;
  assign echo_o  = echo_q;
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_clr_i,
  output logic              wr_ready_o,
  output logic              wr_done_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rd_accept_i,
  input  logic              rd_clr_i
);
  localparam int unsigned FWD_W = 2;
  localparam int unsigned BCK_W = 3;

  logic              wr_req, wr_clr;
  logic [DATA_W-1:0] wr_hold;
  logic              rd_req_s, rd_clr_s;
  logic              rd_take, rd_drop, rd_echo;
  logic              wr_take_s, wr_drop_s, wr_echo_s;
  logic [FWD_W-1:0]  fwd_s;
  logic [BCK_W-1:0]  bck_s;

  xmb_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk_i    (wr_clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (wr_valid_i),
    .data_i   (wr_data_i),
    .clr_i    (wr_clr_i),
    .ready_o  (wr_ready_o),
    .done_o   (wr_done_o),
    .req_o    (wr_req),
    .data_o   (wr_hold),
    .clr_o    (wr_clr),
    .take_s_i (wr_take_s),
    .drop_s_i (wr_drop_s),
    .echo_s_i (wr_echo_s)
  );

  xmb_sync #(.STAGES(SYNC_STAGES), .WIDTH(FWD_W)) u_sync_fwd (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wr_clr, wr_req}),
    .q_o    (fwd_s)
  );
  assign {rd_clr_s, rd_req_s} = fwd_s;

  xmb_rd_side u_rd (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .req_s_i  (rd_req_s),
    .clr_s_i  (rd_clr_s),
    .accept_i (rd_accept_i),
    .clr_i    (rd_clr_i),
    .valid_o  (rd_valid_o),
    .take_o   (rd_take),
    .drop_o   (rd_drop),
    .echo_o   (rd_echo)
  );

  xmb_sync #(.STAGES(SYNC_STAGES), .WIDTH(BCK_W)) u_sync_bck (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rd_echo, rd_drop, rd_take}),
    .q_o    (bck_s)
  );
  assign {wr_echo_s, wr_drop_s, wr_take_s} = bck_s;

  // word is held static by the write side for the whole handshake
  assign rd_data_o = wr_hold;
endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              wr_clr_i,
  input logic              wr_ready_o,
  input logic              wr_done_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_accept_i,
  input logic              rd_clr_i,
  input logic              rd_clr_s
);
  // R5
  done_pulse_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);
  // R5
  done_while_busy_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_done_o |-> !wr_ready_o);
  // R9
  hold_stable_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> $stable(rd_data_o));
  // R8
  clr_wins_wr_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_ready_o && wr_valid_i && wr_clr_i) |=> (!wr_ready_o && $stable(rd_data_o)));
  // R4
  valid_held_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_accept_i && !rd_clr_i) |=> (rd_valid_o || rd_clr_s));
  // R7
  rd_clr_drop_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_clr_i) |=> !rd_valid_o);
  // R5
  accept_drop_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_accept_i) |=> !rd_valid_o);
  // R4
  rd_data_stable_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_accept_i && !rd_clr_i) |=> $stable(rd_data_o));
endmodule

bind xdom_mailbox xdom_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_clr_i    (wr_clr_i),
  .wr_ready_o  (wr_ready_o),
  .wr_done_o   (wr_done_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rd_accept_i (rd_accept_i),
  .rd_clr_i    (rd_clr_i),
  .rd_clr_s    (rd_clr_s)
);

// File: tb/xdom_mailbox_tb.sv
module xdom_mailbox_tb_top;
  localparam int unsigned DW      = 32;
  localparam time         WR_PER  = 10ns;
  localparam time         RD_PER  = 14ns;

  logic          wr_clk = 1'b0, rd_free = 1'b0, same_clk = 1'b1;
  logic          rd_clk;
  logic          rst_ni = 1'b0;
  logic          wr_valid_i = 1'b0, wr_clr_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_accept_i = 1'b0, rd_clr_i = 1'b0;
  logic          wr_ready_o, wr_done_o, rd_valid_o;
  logic [DW-1:0] rd_data_o;

  int n_tests = 0, n_fail = 0, done_cnt = 0;

  always #(WR_PER/2) wr_clk = ~wr_clk;
  always #(RD_PER/2) rd_free = ~rd_free;
  assign rd_clk = same_clk ? wr_clk : rd_free;

  always @(negedge wr_clk) if (rst_ni && wr_done_o) done_cnt++;

  xdom_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_clr_i(wr_clr_i),
    .wr_ready_o(wr_ready_o), .wr_done_o(wr_done_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_accept_i(rd_accept_i), .rd_clr_i(rd_clr_i)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_wr_ready(input string req);
    int n = 0;
    while (!wr_ready_o && n < 200) begin @(negedge wr_clk); n++; end
    check(wr_ready_o === 1'b1, req, {31'd0, wr_ready_o}, 1);
  endtask

  task automatic wait_rd_valid(input string req);
    int n = 0;
    while (!rd_valid_o && n < 200) begin @(negedge rd_clk); n++; end
    check(rd_valid_o === 1'b1, req, {31'd0, rd_valid_o}, 1);
  endtask

  // drive one write, returns after the negedge following the taking edge
  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_data_i = d; wr_valid_i = 1'b1;
    @(negedge wr_clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check(wr_ready_o === 1'b1, "R1 ready", {31'd0, wr_ready_o}, 1);
    check(rd_valid_o === 1'b0, "R1 valid", {31'd0, rd_valid_o}, 0);
    check(wr_done_o === 1'b0, "R1 done", {31'd0, wr_done_o}, 0);
  endtask

  task automatic t_basic_timing;
    int d0;
    do_write(32'hA5A5_0001);
    check(wr_ready_o === 1'b0, "R2 ready low after write", {31'd0, wr_ready_o}, 0);
    @(negedge wr_clk);
    check(rd_valid_o === 1'b0, "R2 valid not yet", {31'd0, rd_valid_o}, 0);
    @(negedge wr_clk);
    check(rd_valid_o === 1'b1, "R2 valid due", {31'd0, rd_valid_o}, 1);
    check(rd_data_o === 32'hA5A5_0001, "R2 data", rd_data_o, 32'hA5A5_0001);
    // R3: write while full is ignored
    do_write(32'hDEAD_BEEF);
    check(rd_data_o === 32'hA5A5_0001, "R3 data kept", rd_data_o, 32'hA5A5_0001);
    // R4: valid held
    repeat (10) @(negedge wr_clk);
    check(rd_valid_o === 1'b1, "R4 valid held", {31'd0, rd_valid_o}, 1);
    d0 = done_cnt;
    rd_accept_i = 1'b1;
    @(negedge wr_clk);
    rd_accept_i = 1'b0;
    check(rd_valid_o === 1'b0, "R5 valid falls", {31'd0, rd_valid_o}, 0);
    @(negedge wr_clk);
    check(wr_done_o === 1'b0, "R5 done not yet", {31'd0, wr_done_o}, 0);
    @(negedge wr_clk);
    check(wr_done_o === 1'b1, "R5 done due", {31'd0, wr_done_o}, 1);
    check(wr_ready_o === 1'b0, "R5 ready still low", {31'd0, wr_ready_o}, 0);
    @(negedge wr_clk);
    check(wr_done_o === 1'b0, "R5 done one cycle", {31'd0, wr_done_o}, 0);
    check(wr_ready_o === 1'b1, "R5 ready back", {31'd0, wr_ready_o}, 1);
    repeat (10) @(negedge wr_clk);
    check(rd_valid_o === 1'b0, "R3 no second word", {31'd0, rd_valid_o}, 0);
    check(done_cnt == d0 + 1, "R5 done count", done_cnt, d0 + 1);
  endtask

  task automatic t_accept_idle;
    rd_accept_i = 1'b1;
    repeat (3) @(negedge wr_clk);
    rd_accept_i = 1'b0;
    check(wr_ready_o === 1'b1, "R4 idle accept no effect", {31'd0, wr_ready_o}, 1);
    do_write(32'h0000_1234);
    wait_rd_valid("R4 later word delivered");
    check(rd_data_o === 32'h0000_1234, "R4 data", rd_data_o, 32'h0000_1234);
    rd_accept_i = 1'b1; @(negedge wr_clk); rd_accept_i = 1'b0;
    wait_wr_ready("R4 ready back");
  endtask

  task automatic t_wr_clear;
    int d0 = done_cnt;
    do_write(32'h5555_AAAA);
    wait_rd_valid("R6 word shown");
    @(negedge wr_clk); wr_clr_i = 1'b1;
    @(negedge wr_clk); wr_clr_i = 1'b0;
    wait_wr_ready("R6 ready restored");
    check(rd_valid_o === 1'b0, "R6 valid dropped", {31'd0, rd_valid_o}, 0);
    repeat (20) @(negedge wr_clk);
    check(rd_valid_o === 1'b0, "R6 no reappear", {31'd0, rd_valid_o}, 0);
    check(done_cnt == d0, "R6 no done", done_cnt, d0);
  endtask

  task automatic t_rd_clear;
    int d0 = done_cnt;
    do_write(32'h0F0F_0F0F);
    wait_rd_valid("R7 word shown");
    rd_clr_i = 1'b1;
    @(negedge wr_clk);
    rd_clr_i = 1'b0;
    check(rd_valid_o === 1'b0, "R7 valid falls", {31'd0, rd_valid_o}, 0);
    wait_wr_ready("R7 ready restored");
    repeat (10) @(negedge wr_clk);
    check(done_cnt == d0, "R7 no done", done_cnt, d0);
  endtask

  task automatic t_clear_priority;
    int d0 = done_cnt;
    bit seen = 1'b0;
    @(negedge wr_clk);
    wr_data_i = 32'h7777_7777; wr_valid_i = 1'b1; wr_clr_i = 1'b1;
    @(negedge wr_clk);
    wr_valid_i = 1'b0; wr_clr_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge wr_clk);
      if (rd_valid_o) seen = 1'b1;
    end
    check(!seen, "R8 write lost to clear", {31'd0, seen}, 0);
    check(wr_ready_o === 1'b1, "R8 ready", {31'd0, wr_ready_o}, 1);
    // read side: clear with accept counts as discard
    do_write(32'h1111_2222);
    wait_rd_valid("R8 word shown");
    rd_accept_i = 1'b1; rd_clr_i = 1'b1;
    @(negedge wr_clk);
    rd_accept_i = 1'b0; rd_clr_i = 1'b0;
    wait_wr_ready("R8 ready after rd clear");
    repeat (5) @(negedge wr_clk);
    check(done_cnt == d0, "R8 no done", done_cnt, d0);
  endtask

  task automatic t_async_stream;
    int d0;
    same_clk = 1'b0;
    repeat (4) @(negedge wr_clk);
    d0 = done_cnt;
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] w;
      w = 32'hC0DE_0000 + DW'(k * 37);
      wait_wr_ready("R10 ready");
      do_write(w);
      wait_rd_valid("R10 valid");
      check(rd_data_o === w, "R10 data order", rd_data_o, w);
      @(negedge rd_clk); rd_accept_i = 1'b1;
      @(negedge rd_clk); rd_accept_i = 1'b0;
    end
    wait_wr_ready("R10 final ready");
    repeat (4) @(negedge wr_clk);
    check(done_cnt == d0 + 6, "R10 done per word", done_cnt, d0 + 6);
  endtask

  initial begin
    repeat (3) @(negedge wr_clk);
    rst_ni = 1'b1;
    @(negedge wr_clk);
    t_reset();
    t_basic_timing();
    t_accept_idle();
    t_wr_clear();
    t_rd_clear();
    t_clear_priority();
    t_async_stream();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule